// File: doc/BRIEF.md
# Quad I/O Continuous Read Sequencer

This block is the device-side sequencer of a serial flash that serves fast reads over four bidirectional data lines. A transaction begins with an 8-clock opcode on line 0. Three opcodes are accepted, each a read variant: a plain quad read, a 16-bit-aligned word read and a 16-byte-aligned octal word read. After the opcode come six address nibbles, two mode nibbles and a variant-dependent run of dummy clocks. The block then streams bytes from a synchronous memory read port, high nibble first, and advances the address after every byte until chip select rises.

A mode byte whose upper nibble is Ah arms a continuous mode. The next transaction then skips the opcode and begins directly with the address, using the variant that armed it. Any other mode value disarms the block for the following transaction. Eight clocks with all four lines high form the mode-reset sequence, because it clocks FFh into the mode field. The serial clock and chip select are sampled in the system clock domain. Each serial clock level must last at least two system clocks, and chip select must fall at least one system clock before the first serial rising edge.

Top module: `qio_read_seq`

## Requirements
- R1: After reset the IO lines are not driven (`io_oe`=0), `mem_rd` is low and continuous mode is disarmed, so the first transaction must carry an opcode.
- R2: Opcode EBh is taken MSB first on `io_in[0]` over 8 serial rising edges. It is followed by 6 address nibbles and then 2 mode nibbles, both MSB first with `io_in[3]` as the most significant bit of each nibble, and then by 4 dummy clocks. `io_oe` stays 0 through opcode, address and mode.
- R3: Read data is driven on falling serial edges, starting with the falling edge that follows the last dummy rising edge (or the last mode edge when there are no dummies). Each byte goes out high nibble first. The address advances by one per byte, and each transaction issues exactly one single-cycle `mem_rd` pulse per byte plus one for the start address.
- R4: Only the low ADDR_W (21) address bits are used. Streaming past address 2^ADDR_W-1 continues at address 0.
- R5: Opcode E7h forces address bit 0 to zero and uses 2 dummy clocks.
- R6: Opcode E3h forces address bits 3..0 to zero and uses no dummy clocks.
- R7: A mode byte with upper nibble Ah arms continuous mode. The next transaction then starts with the address and reuses the armed variant with its alignment and dummy count.
- R8: A mode byte with any other upper nibble disarms the block, effective for the next transaction. Eight clocks with all IO lines high while armed (mode reset) restore opcode decoding.
- R9: Chip select high releases the IO lines within one system clock and returns to idle. The armed state is kept even if the transaction is cut short before its mode field.
- R10: An unsupported opcode makes the block ignore the rest of the transaction: no IO drive and no memory reads until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, sampled by clk |
| cs_n | input | 1 | Chip select, active low |
| io_in | input | 4 | Incoming value of the four IO lines |
| io_out | output | 4 | Value driven onto the IO lines |
| io_oe | output | 1 | Output enable for all four IO lines |
| mem_rd | output | 1 | Memory read strobe, one cycle |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the strobe |

## Verification
The most delicate overlap is between the prefetch for the next byte and the output of the current byte's low nibble. Both hang off the same falling serial edge, so a prefetch that lands too early or too late shows up as a byte repeated or skipped. Multi-byte reads check every byte against a bench memory pattern and count read strobes, both across the top of the address space and in the aligned word variants. The second overlap is the arm/disarm decision against a chip select that rises early. Aborted armed transactions are followed by address-first reads whose data must still come back correct.

// File: rtl/qio_pkg.sv
package qio_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_MODE,
        PH_DUMMY,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        VAR_QUAD,
        VAR_WORD,
        VAR_OCT
    } variant_e;

    localparam logic [7:0] OP_QUAD    = 8'hEB;
    localparam logic [7:0] OP_WORD    = 8'hE7;
    localparam logic [7:0] OP_OCT     = 8'hE3;
    localparam logic [3:0] ARM_NIBBLE = 4'hA;

    function automatic logic op_known(input logic [7:0] op);
        return (op == OP_QUAD) || (op == OP_WORD) || (op == OP_OCT);
    endfunction

    function automatic variant_e op_variant(input logic [7:0] op);
        case (op)
            OP_WORD: return VAR_WORD;
            OP_OCT:  return VAR_OCT;
            default: return VAR_QUAD;
        endcase
    endfunction

    function automatic logic [2:0] dummy_clks(input variant_e v);
        case (v)
            VAR_WORD: return 3'd2;
            VAR_OCT:  return 3'd0;
            default:  return 3'd4;
        endcase
    endfunction

    // low address bits that the variant forces to zero
    function automatic logic [3:0] align_mask(input variant_e v);
        case (v)
            VAR_WORD: return 4'b0001;
            VAR_OCT:  return 4'b1111;
            default:  return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/qio_sck_edge.sv
module qio_sck_edge (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    output logic rise,
    output logic fall
);
    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck;
    end

    assign rise = sck & ~sck_q;
    assign fall = ~sck & sck_q;
endmodule

// File: rtl/qio_phase_ctl.sv
module qio_phase_ctl
    import qio_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rise,
    input  logic [3:0]        io_in,
    output phase_e            phase,
    output logic              armed,
    output logic              start,
    output logic [ADDR_W-1:0] start_addr
);
    localparam int SH_W = ADDR_W - 4;

    logic [2:0]        cnt;
    logic [7:0]        sh;
    logic [SH_W-1:0]   addr_sh;
    variant_e          var_q;
    logic [ADDR_W-1:0] raw_addr;
    logic [7:0]        op_full;

    assign raw_addr = {addr_sh, io_in};
    assign op_full  = {sh[6:0], io_in[0]};

    always_ff @(posedge clk) begin
        start <= 1'b0;
        if (rst) begin
            phase      <= PH_IDLE;
            armed      <= 1'b0;
            var_q      <= VAR_QUAD;
            cnt        <= '0;
            sh         <= '0;
            addr_sh    <= '0;
            start_addr <= '0;
        end else if (cs_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    phase <= armed ? PH_ADDR : PH_CMD;
                    cnt   <= '0;
                end
                PH_CMD: if (rise) begin
                    sh  <= op_full;
                    cnt <= cnt + 3'd1;
                    if (cnt == 3'd7) begin
                        cnt <= '0;
                        if (op_known(op_full)) begin
                            var_q <= op_variant(op_full);
                            phase <= PH_ADDR;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                end
                PH_ADDR: if (rise) begin
                    addr_sh <= raw_addr[SH_W-1:0];
                    cnt     <= cnt + 3'd1;
                    if (cnt == 3'd5) begin
                        cnt        <= '0;
                        phase      <= PH_MODE;
                        start      <= 1'b1;
                        start_addr <= raw_addr & ~{{SH_W{1'b0}}, align_mask(var_q)};
                    end
                end
                PH_MODE: if (rise) begin
                    sh  <= {sh[3:0], io_in};
                    cnt <= cnt + 3'd1;
                    if (cnt == 3'd1) begin
                        cnt   <= '0;
                        armed <= (sh[3:0] == ARM_NIBBLE);
                        phase <= (dummy_clks(var_q) == 3'd0) ? PH_DATA : PH_DUMMY;
                    end
                end
                PH_DUMMY: if (rise) begin
                    cnt <= cnt + 3'd1;
                    if (cnt == dummy_clks(var_q) - 3'd1) begin
                        cnt   <= '0;
                        phase <= PH_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    // R8
    arm_change_chk: assert property (@(posedge clk) disable iff (rst)
        (armed != $past(armed)) |-> ($past(phase) == PH_MODE));

    // R9
    idle_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n) |-> (phase == PH_IDLE));
endmodule

// File: rtl/qio_stream_out.sv
module qio_stream_out
    import qio_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              fall,
    input  phase_e            phase,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [3:0]        io_out,
    output logic              io_oe
);
    logic [ADDR_W-1:0] cur;
    logic              pend;
    logic [7:0]        buf_q;
    logic [7:0]        hold;
    logic              nib;

    always_ff @(posedge clk) begin
        mem_rd <= 1'b0;
        if (rst) begin
            cur      <= '0;
            mem_addr <= '0;
            pend     <= 1'b0;
            buf_q    <= '0;
            hold     <= '0;
            nib      <= 1'b0;
            io_out   <= '0;
            io_oe    <= 1'b0;
        end else begin
            pend <= mem_rd;
            if (pend) buf_q <= mem_rdata;
            if (cs_n) begin
                io_oe  <= 1'b0;
                io_out <= '0;
                nib    <= 1'b0;
            end else if (start) begin
                cur      <= start_addr;
                mem_addr <= start_addr;
                mem_rd   <= 1'b1;
                nib      <= 1'b0;
            end else if (fall && phase == PH_DATA) begin
                io_oe <= 1'b1;
                if (!nib) begin
                    io_out   <= buf_q[7:4];
                    hold     <= buf_q;
                    cur      <= cur + 1'b1;
                    mem_addr <= cur + 1'b1;
                    mem_rd   <= 1'b1;
                    nib      <= 1'b1;
                end else begin
                    io_out <= hold[3:0];
                    nib    <= 1'b0;
                end
            end
        end
    end

    // R3
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R3
    nibble_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (io_oe && $past(io_oe) && !$past(fall)) |-> $stable(io_out));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n) |-> !io_oe);
endmodule

// File: rtl/qio_read_seq.sv
module qio_read_seq
    import qio_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              cs_n,
    input  logic [3:0]        io_in,
    output logic [3:0]        io_out,
    output logic              io_oe,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);
    logic              rise;
    logic              fall;
    phase_e            phase;
    logic              armed;
    logic              start;
    logic [ADDR_W-1:0] start_addr;

    qio_sck_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sck  (sck),
        .rise (rise),
        .fall (fall)
    );

    qio_phase_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .rise       (rise),
        .io_in      (io_in),
        .phase      (phase),
        .armed      (armed),
        .start      (start),
        .start_addr (start_addr)
    );

    qio_stream_out #(.ADDR_W(ADDR_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .fall       (fall),
        .phase      (phase),
        .start      (start),
        .start_addr (start_addr),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .io_out     (io_out),
        .io_oe      (io_oe)
    );

    // R10
    skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> (!mem_rd && !io_oe));

    // R2
    header_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CMD || phase == PH_ADDR) |-> !io_oe);
endmodule

// File: tb/qio_read_seq_tb.sv
module qio_read_seq_tb;
    localparam int ADDR_W = 21;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sck = 1'b0;
    logic              cs_n = 1'b1;
    logic [3:0]        io_in = '0;
    logic [3:0]        io_out;
    logic              io_oe;
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_rdata = '0;

    int tests = 0;
    int fails = 0;
    int rd_seen = 0;

    always #4 clk = ~clk;

    qio_read_seq #(.ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .sck       (sck),
        .cs_n      (cs_n),
        .io_in     (io_in),
        .io_out    (io_out),
        .io_oe     (io_oe),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h3C;
    endfunction

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= pat(mem_addr);
        if (mem_rd) rd_seen <= rd_seen + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_clk(input logic [3:0] d, output logic [3:0] q, output logic oe);
        @(negedge clk); io_in = d; sck = 1'b1;
        @(negedge clk);
        @(negedge clk); sck = 1'b0;
        @(negedge clk);
        @(negedge clk); q = io_out; oe = io_oe;
    endtask

    task automatic read_txn(input bit send_op, input logic [7:0] op, input logic [23:0] addr,
                            input logic [7:0] mode, input int ndummy, input int nbytes,
                            input logic [ADDR_W-1:0] exp_start, input string req);
        logic [3:0]        q;
        logic              oe;
        logic [3:0]        hi;
        logic [ADDR_W-1:0] ea;
        bit                early;
        early = 1'b0;
        @(negedge clk); rd_seen = 0; cs_n = 1'b0;
        @(negedge clk);
        if (send_op)
            for (int i = 7; i >= 0; i--) begin
                spi_clk({3'b000, op[i]}, q, oe);
                if (oe) early = 1'b1;
            end
        for (int i = 5; i >= 0; i--) begin
            spi_clk(addr[i*4 +: 4], q, oe);
            if (oe) early = 1'b1;
        end
        spi_clk(mode[7:4], q, oe);
        if (oe) early = 1'b1;
        check(!early, {req, " header io_oe (R2)"}, 32'(early), 0);
        spi_clk(mode[3:0], q, oe);
        for (int i = 0; i < ndummy; i++) spi_clk(4'h0, q, oe);
        ea = exp_start;
        for (int b = 0; b < nbytes; b++) begin
            if (b != 0) spi_clk(4'h0, q, oe);
            hi = q;
            check(oe, {req, " data io_oe (R3)"}, 32'(oe), 1);
            spi_clk(4'h0, q, oe);
            check({hi, q} == pat(ea), {req, " data byte (R3)"}, {hi, q}, pat(ea));
            ea = ea + 1'b1;
        end
        @(negedge clk); cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check(io_oe == 1'b0, {req, " release (R9)"}, 32'(io_oe), 0);
        check(rd_seen == nbytes + 1, {req, " read count (R3)"}, rd_seen, nbytes + 1);
    endtask

    task automatic mode_reset();
        logic [3:0] q;
        logic       oe;
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 8; i++) spi_clk(4'hF, q, oe);
        @(negedge clk); cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check(io_oe == 1'b0, "R1 io_oe after reset", 32'(io_oe), 0);
        check(mem_rd == 1'b0, "R1 mem_rd after reset", 32'(mem_rd), 0);
        read_txn(1, 8'hEB, 24'h000040, 8'h00, 4, 1, 21'h000040, "R1 first txn");
    endtask

    task automatic t_basic();
        read_txn(1, 8'hEB, 24'h012345, 8'h00, 4, 4, 21'h012345, "R2 quad read");
        read_txn(1, 8'hEB, 24'hE00010, 8'h00, 4, 2, 21'h000010, "R4 upper bits");
        read_txn(1, 8'hEB, 24'h1FFFFE, 8'h12, 4, 4, 21'h1FFFFE, "R4 wrap");
    endtask

    task automatic t_variants();
        read_txn(1, 8'hE7, 24'h000101, 8'h00, 2, 3, 21'h000100, "R5 word read");
        read_txn(1, 8'hE3, 24'h00003B, 8'h00, 0, 3, 21'h000030, "R6 octal read");
    endtask

    task automatic t_continuous();
        logic [3:0] q;
        logic       oe;
        read_txn(1, 8'hEB, 24'h000200, 8'hA5, 4, 2, 21'h000200, "R7 arm");
        read_txn(0, 8'h00, 24'h000300, 8'hA0, 4, 2, 21'h000300, "R7 no opcode");
        // abort inside the address while armed
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) spi_clk(4'h7, q, oe);
        @(negedge clk); cs_n = 1'b1;
        repeat (3) @(negedge clk);
        read_txn(0, 8'h00, 24'h000400, 8'hAF, 4, 2, 21'h000400, "R9 armed kept");
        mode_reset();
        read_txn(1, 8'hEB, 24'h000500, 8'h00, 4, 2, 21'h000500, "R8 after mode reset");
        read_txn(1, 8'hEB, 24'h000600, 8'hA0, 4, 1, 21'h000600, "R7 rearm");
        read_txn(0, 8'h00, 24'h000700, 8'h50, 4, 1, 21'h000700, "R8 disarm value");
        read_txn(1, 8'hEB, 24'h000800, 8'h00, 4, 2, 21'h000800, "R8 opcode again");
        read_txn(1, 8'hE7, 24'h000101, 8'hA0, 2, 2, 21'h000100, "R7 arm word");
        read_txn(0, 8'h00, 24'h000203, 8'h00, 2, 2, 21'h000202, "R7 word variant kept");
    endtask

    task automatic t_skip();
        logic [3:0] q;
        logic       oe;
        bit         drove;
        logic [7:0] op;
        drove = 1'b0;
        op = 8'h03;
        @(negedge clk); rd_seen = 0; cs_n = 1'b0;
        @(negedge clk);
        for (int i = 7; i >= 0; i--) spi_clk({3'b000, op[i]}, q, oe);
        for (int i = 0; i < 14; i++) begin
            spi_clk(4'h5, q, oe);
            if (oe) drove = 1'b1;
        end
        check(!drove, "R10 no drive", 32'(drove), 0);
        check(rd_seen == 0, "R10 no reads", rd_seen, 0);
        @(negedge clk); cs_n = 1'b1;
        repeat (3) @(negedge clk);
        read_txn(1, 8'hEB, 24'h000900, 8'h00, 4, 1, 21'h000900, "R10 recovery");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_variants();
        t_continuous();
        t_skip();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule